// File: doc/BRIEF.md
# Core Thread Direct-Control Register Bank

This block sits on a 64-bit register access bus next to a multi-threaded processor core. Software uses it to issue low-level commands to individual hardware threads and to read back their run state. A write to the direct-control register is split into per-thread command lanes of eight bits each. Each recognised command bit becomes a one-cycle pulse on that thread's stop, start, soft-reset or clear-maintenance output.

The bank keeps one stopped flag per thread, updated by the commands in a fixed order. It reports that flag through the RAS-status register. It also reports the core's per-thread halted inputs through the thread-state register. Bits of the data word are numbered MSB-first: bit n has weight 2^(63-n). A write that carries bits outside the recognised command set, or an access to an index the bank does not serve, raises a one-cycle event output.

Top module: `core_ctl_bank`

## Requirements
- R1: After reset every pulse output, `rd_valid`, `unimpl_bits` and `unimpl_access` are 0, and every thread's stopped flag is clear, so a RAS-status read returns 0.
- R2: The register index is `req_addr >> 3`. Address bits [2:0] do not affect decoding. Thread-state is index 0x412, thread-info 0x413, direct-control 0x449, RAS-status 0x454.
- R3: A read is answered one cycle after it is accepted, with `rd_valid` high for exactly that cycle. A thread-state read sets MSB-first bit 56+i (`rd_data[7-i]`) for each thread i whose `thr_halted[i]` is 1. All other bits are 0.
- R4: A RAS-status read sets MSB-first bits 8i and 8i+1 (`rd_data[63-8i]` and `rd_data[62-8i]`) for each thread i whose stopped flag is set. All other bits are 0.
- R5: In a direct-control write, MSB-first bit 8i+7 (`wdata[56-8i]`) is stop for thread i, bit 8i+6 (`wdata[57-8i]`) is start, bit 8i+4 (`wdata[59-8i]`) is soft reset and bit 8i+3 (`wdata[60-8i]`) is clear-maintenance. Each set bit yields a pulse on the matching output bit i in the cycle after the write, lasting one cycle.
- R6: Commands in one write apply in the order stop, start, soft reset, clear-maintenance. Stop sets the thread's stopped flag and start clears it, so stop and start together leave the flag clear. Soft reset does not change the flag. The flag is visible to a RAS-status read issued in the next cycle.
- R7: Clear-maintenance clears the stopped flag exactly as start does, and it pulses its own output.
- R8: A direct-control write that has any bit set outside the recognised command bits of the present threads pulses `unimpl_bits` for one cycle after the write. Command bits for thread indices at or above `NT` count as unrecognised and produce no pulse.
- R9: A thread-info read returns 0 regardless of the inputs.
- R10: A read of any index other than thread-state, thread-info or RAS-status, and a write to any index other than direct-control, pulse `unimpl_access` one cycle later. Such a read returns 0 with `rd_valid`. Such a write produces no command pulse and no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 64 | Write data, MSB-first numbering |
| thr_halted | input | NT | Per-thread halted status from the core |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 64 | Read data |
| stop_pulse | output | NT | Per-thread stop command pulse |
| start_pulse | output | NT | Per-thread start command pulse |
| sreset_pulse | output | NT | Per-thread soft-reset command pulse |
| clrmnt_pulse | output | NT | Per-thread clear-maintenance command pulse |
| unimpl_bits | output | 1 | Unrecognised direct-control bits seen |
| unimpl_access | output | 1 | Access to an unserved index or direction |

## Verification
The assertions assume that no request is presented while reset is high. They also assume that `req_write` is meaningful only when `req_valid` is set. Under those conditions every response, command pulse and event pulse can be traced back to an accepted request in the cycle before. The directed bench drives requests only after reset is released. It holds every request for exactly one clock and returns `req_valid` low between scenarios. A second instance with two threads shares the same stimulus to cover command lanes for absent threads.

// File: rtl/core_ctl_pkg.sv
package core_ctl_pkg;

  localparam int unsigned DATA_W = 64;
  localparam int unsigned LANE_W = 8;

  // register indices (byte address >> 3)
  localparam int unsigned IDX_THR_STATE = 32'h412;
  localparam int unsigned IDX_THR_INFO  = 32'h413;
  localparam int unsigned IDX_DIR_CTL   = 32'h449;
  localparam int unsigned IDX_RAS_STAT  = 32'h454;

  // command offsets inside a thread lane (MSB-first)
  localparam int unsigned OFF_STOP   = 7;
  localparam int unsigned OFF_START  = 6;
  localparam int unsigned OFF_SRESET = 4;
  localparam int unsigned OFF_CLRMNT = 3;

  // RAS-status flag offsets inside a thread lane (MSB-first)
  localparam int unsigned OFF_RAS_A = 0;
  localparam int unsigned OFF_RAS_B = 1;

  // thread-state base bit (MSB-first)
  localparam int unsigned THR_STATE_BASE = 56;

  typedef struct packed {
    logic stop;
    logic start;
    logic sreset;
    logic clrmnt;
  } thr_cmd_t;

  // convert an MSB-first bit number into an LSB-first vector index
  function automatic int unsigned msb0(input int unsigned n);
    return DATA_W - 1 - n;
  endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import core_ctl_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic [DATA_W-1:0]  wdata,
  output thr_cmd_t [NT-1:0]  cmd,
  output logic               leftover
);

  logic [DATA_W-1:0] known_mask;

  for (genvar t = 0; t < NT; t++) begin : g_lane
    localparam int unsigned BASE = LANE_W * t;
    assign cmd[t].stop   = wdata[msb0(BASE + OFF_STOP)];
    assign cmd[t].start  = wdata[msb0(BASE + OFF_START)];
    assign cmd[t].sreset = wdata[msb0(BASE + OFF_SRESET)];
    assign cmd[t].clrmnt = wdata[msb0(BASE + OFF_CLRMNT)];
  end

  always_comb begin
    known_mask = '0;
    for (int t = 0; t < NT; t++) begin
      known_mask[msb0(LANE_W * t + OFF_STOP)]   = 1'b1;
      known_mask[msb0(LANE_W * t + OFF_START)]  = 1'b1;
      known_mask[msb0(LANE_W * t + OFF_SRESET)] = 1'b1;
      known_mask[msb0(LANE_W * t + OFF_CLRMNT)] = 1'b1;
    end
  end

  assign leftover = |(wdata & ~known_mask);

endmodule

// File: rtl/thread_ctl.sv
module thread_ctl
  import core_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fire,
  input  thr_cmd_t cmd,
  output logic     stop_p,
  output logic     start_p,
  output logic     sreset_p,
  output logic     clrmnt_p,
  output logic     stopped
);

  logic stopped_nxt;

  // ordered application: stop, start, soft reset (no flag effect), clear-maint
  always_comb begin
    stopped_nxt = stopped;
    if (fire) begin
      if (cmd.stop)   stopped_nxt = 1'b1;
      if (cmd.start)  stopped_nxt = 1'b0;
      if (cmd.clrmnt) stopped_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_p   <= 1'b0;
      start_p  <= 1'b0;
      sreset_p <= 1'b0;
      clrmnt_p <= 1'b0;
      stopped  <= 1'b0;
    end else begin
      stop_p   <= fire & cmd.stop;
      start_p  <= fire & cmd.start;
      sreset_p <= fire & cmd.sreset;
      clrmnt_p <= fire & cmd.clrmnt;
      stopped  <= stopped_nxt;
    end
  end

endmodule

// File: rtl/read_mux.sv
module read_mux
  import core_ctl_pkg::*;
#(
  parameter int NT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic              sel_state,
  input  logic              sel_ras,
  input  logic [NT-1:0]     halted,
  input  logic [NT-1:0]     stopped,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] state_word;
  logic [DATA_W-1:0] ras_word;
  logic [DATA_W-1:0] mux_word;

  always_comb begin
    state_word = '0;
    ras_word   = '0;
    for (int t = 0; t < NT; t++) begin
      state_word[msb0(THR_STATE_BASE + t)]       = halted[t];
      ras_word[msb0(LANE_W * t + OFF_RAS_A)]     = stopped[t];
      ras_word[msb0(LANE_W * t + OFF_RAS_B)]     = stopped[t];
    end
    // thread-info and unserved indices read as zero
    mux_word = '0;
    if (sel_state) mux_word = state_word;
    if (sel_ras)   mux_word = ras_word;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= mux_word;
    end
  end

endmodule

// File: rtl/core_ctl_bank.sv
module core_ctl_bank
  import core_ctl_pkg::*;
#(
  parameter int NT     = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [NT-1:0]     thr_halted,
  output logic              rd_valid,
  output logic [63:0]       rd_data,
  output logic [NT-1:0]     stop_pulse,
  output logic [NT-1:0]     start_pulse,
  output logic [NT-1:0]     sreset_pulse,
  output logic [NT-1:0]     clrmnt_pulse,
  output logic              unimpl_bits,
  output logic              unimpl_access
);

  localparam int IDX_W = ADDR_W - 3;

  logic [IDX_W-1:0] idx;
  logic hit_state, hit_info, hit_dc, hit_ras;
  logic rd_req, wr_req, wr_dc, bad_acc;
  thr_cmd_t [NT-1:0] cmd;
  logic leftover;
  logic [NT-1:0] stopped;

  assign idx       = req_addr[ADDR_W-1:3];
  assign hit_state = (idx == IDX_W'(IDX_THR_STATE));
  assign hit_info  = (idx == IDX_W'(IDX_THR_INFO));
  assign hit_dc    = (idx == IDX_W'(IDX_DIR_CTL));
  assign hit_ras   = (idx == IDX_W'(IDX_RAS_STAT));

  assign rd_req  = req_valid & ~req_write;
  assign wr_req  = req_valid &  req_write;
  assign wr_dc   = wr_req & hit_dc;
  assign bad_acc = (rd_req & ~(hit_state | hit_info | hit_ras)) |
                   (wr_req & ~hit_dc);

  cmd_decode #(.NT(NT)) u_dec (
    .wdata    (req_wdata),
    .cmd      (cmd),
    .leftover (leftover)
  );

  for (genvar t = 0; t < NT; t++) begin : g_thr
    thread_ctl u_thr (
      .clk      (clk),
      .rst      (rst),
      .fire     (wr_dc),
      .cmd      (cmd[t]),
      .stop_p   (stop_pulse[t]),
      .start_p  (start_pulse[t]),
      .sreset_p (sreset_pulse[t]),
      .clrmnt_p (clrmnt_pulse[t]),
      .stopped  (stopped[t])
    );
  end

  read_mux #(.NT(NT)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .sel_state (hit_state),
    .sel_ras   (hit_ras),
    .halted    (thr_halted),
    .stopped   (stopped),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      unimpl_bits   <= 1'b0;
      unimpl_access <= 1'b0;
    end else begin
      unimpl_bits   <= wr_dc & leftover;
      unimpl_access <= bad_acc;
    end
  end

endmodule

// File: rtl/core_ctl_bank_chk.sv
module core_ctl_bank_chk #(
  parameter int NT = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_write,
  input logic          rd_valid,
  input logic [NT-1:0] stop_pulse,
  input logic [NT-1:0] start_pulse,
  input logic [NT-1:0] sreset_pulse,
  input logic [NT-1:0] clrmnt_pulse,
  input logic          unimpl_bits,
  input logic          unimpl_access
);

  logic any_pulse;
  assign any_pulse = |{stop_pulse, start_pulse, sreset_pulse, clrmnt_pulse};

  assert_read_answered_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rd_valid);

  assert_no_spurious_valid_R3: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_write));

  assert_pulse_after_write_R5: assert property (@(posedge clk) disable iff (rst)
    any_pulse |-> $past(req_valid && req_write));

  assert_leftover_after_write_R8: assert property (@(posedge clk) disable iff (rst)
    unimpl_bits |-> $past(req_valid && req_write));

  assert_bad_access_no_cmd_R10: assert property (@(posedge clk) disable iff (rst)
    unimpl_access |-> !any_pulse);

  assert_bad_access_after_req_R10: assert property (@(posedge clk) disable iff (rst)
    unimpl_access |-> $past(req_valid));

endmodule

bind core_ctl_bank core_ctl_bank_chk #(.NT(NT)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .rd_valid      (rd_valid),
  .stop_pulse    (stop_pulse),
  .start_pulse   (start_pulse),
  .sreset_pulse  (sreset_pulse),
  .clrmnt_pulse  (clrmnt_pulse),
  .unimpl_bits   (unimpl_bits),
  .unimpl_access (unimpl_access)
);

// File: tb/core_ctl_bank_tb.sv
module core_ctl_bank_tb;

  localparam int NT = 4;
  localparam int AW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [NT-1:0] thr_halted = '0;
  logic rd_valid;
  logic [63:0] rd_data;
  logic [NT-1:0] stop_pulse, start_pulse, sreset_pulse, clrmnt_pulse;
  logic unimpl_bits, unimpl_access;

  logic rd_valid2;
  logic [63:0] rd_data2;
  logic [1:0] stop2, start2, sreset2, clrmnt2;
  logic ub2, ua2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  core_ctl_bank #(.NT(NT), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .thr_halted(thr_halted),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .stop_pulse(stop_pulse), .start_pulse(start_pulse),
    .sreset_pulse(sreset_pulse), .clrmnt_pulse(clrmnt_pulse),
    .unimpl_bits(unimpl_bits), .unimpl_access(unimpl_access)
  );

  core_ctl_bank #(.NT(2), .ADDR_W(AW)) u_dut2 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .thr_halted(thr_halted[1:0]),
    .rd_valid(rd_valid2), .rd_data(rd_data2),
    .stop_pulse(stop2), .start_pulse(start2),
    .sreset_pulse(sreset2), .clrmnt_pulse(clrmnt2),
    .unimpl_bits(ub2), .unimpl_access(ua2)
  );

  localparam logic [AW-1:0] A_STATE = AW'(32'h412) << 3;
  localparam logic [AW-1:0] A_INFO  = AW'(32'h413) << 3;
  localparam logic [AW-1:0] A_DC    = AW'(32'h449) << 3;
  localparam logic [AW-1:0] A_RAS   = AW'(32'h454) << 3;

  // MSB-first bit n of a 64-bit word
  function automatic logic [63:0] mbit(input int n);
    return 64'd1 << (63 - n);
  endfunction
  function automatic logic [63:0] c_stop(input int t);   return mbit(8*t+7); endfunction
  function automatic logic [63:0] c_start(input int t);  return mbit(8*t+6); endfunction
  function automatic logic [63:0] c_sreset(input int t); return mbit(8*t+4); endfunction
  function automatic logic [63:0] c_clrmnt(input int t); return mbit(8*t+3); endfunction
  function automatic logic [63:0] ras_of(input logic [NT-1:0] s);
    logic [63:0] w = '0;
    for (int t = 0; t < NT; t++) if (s[t]) w |= mbit(8*t) | mbit(8*t+1);
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one request for one clock; returns at the negedge where the response is visible
  task automatic access(input logic wr, input logic [AW-1:0] a, input logic [63:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
  endtask

  task automatic read_expect(input string req, input logic [AW-1:0] a, input logic [63:0] exp);
    access(1'b0, a, '0);
    chk(req, {63'd0, rd_valid}, 64'd1);
    chk(req, rd_data, exp);
  endtask

  task automatic pulses_expect(input string req, input logic [NT-1:0] sp, input logic [NT-1:0] st,
                               input logic [NT-1:0] sr, input logic [NT-1:0] cm);
    chk({req, " stop"},   64'(stop_pulse),   64'(sp));
    chk({req, " start"},  64'(start_pulse),  64'(st));
    chk({req, " sreset"}, 64'(sreset_pulse), 64'(sr));
    chk({req, " clrmnt"}, 64'(clrmnt_pulse), 64'(cm));
  endtask

  task automatic t_reset();
    pulses_expect("R1 reset", '0, '0, '0, '0);
    chk("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    chk("R1 unimpl", {62'd0, unimpl_bits, unimpl_access}, 64'd0);
    read_expect("R1 ras after reset", A_RAS, 64'd0);
  endtask

  task automatic t_state();
    thr_halted = 4'b1010;
    read_expect("R3 halted 1010", A_STATE, 64'h50);
    @(negedge clk);
    chk("R3 valid one cycle", {63'd0, rd_valid}, 64'd0);
    thr_halted = 4'b0001;
    read_expect("R3 halted 0001", A_STATE, 64'h80);
    read_expect("R2 low addr bits", A_STATE | AW'(5), 64'h80);
    thr_halted = 4'b1111;
    read_expect("R9 thread-info", A_INFO, 64'd0);
  endtask

  task automatic t_stop_start();
    access(1'b1, A_DC, c_stop(0) | c_stop(2));
    pulses_expect("R5 stop t0 t2", 4'b0101, '0, '0, '0);
    chk("R8 clean write", {63'd0, unimpl_bits}, 64'd0);
    read_expect("R4 ras t0 t2", A_RAS, 64'hC000_C000_0000_0000);
    pulses_expect("R5 single cycle", '0, '0, '0, '0);
    access(1'b1, A_DC, c_start(0));
    pulses_expect("R5 start t0", '0, 4'b0001, '0, '0);
    read_expect("R6 start clears t0", A_RAS, ras_of(4'b0100));
  endtask

  task automatic t_order();
    access(1'b1, A_DC, c_stop(3));
    access(1'b1, A_DC, c_stop(3) | c_start(3));
    pulses_expect("R6 stop+start t3", 4'b1000, 4'b1000, '0, '0);
    read_expect("R6 start wins", A_RAS, ras_of(4'b0100));
    access(1'b1, A_DC, c_clrmnt(2));
    pulses_expect("R7 clrmnt t2", '0, '0, '0, 4'b0100);
    read_expect("R7 clrmnt clears", A_RAS, 64'd0);
    access(1'b1, A_DC, c_stop(1));
    access(1'b1, A_DC, c_sreset(1));
    pulses_expect("R6 sreset t1", '0, '0, 4'b0010, '0);
    read_expect("R6 sreset keeps flag", A_RAS, 64'h00C0_0000_0000_0000);
  endtask

  task automatic t_unimpl();
    access(1'b1, A_DC, mbit(0) | mbit(13));
    chk("R8 leftover bits", {63'd0, unimpl_bits}, 64'd1);
    pulses_expect("R8 no pulses", '0, '0, '0, '0);
    @(negedge clk);
    chk("R8 one cycle", {63'd0, unimpl_bits}, 64'd0);
    access(1'b1, A_DC, c_stop(2));
    chk("R8 absent thread flagged", {63'd0, ub2}, 64'd1);
    chk("R8 absent thread no pulse", {62'd0, stop2}, 64'd0);
    chk("R8 present thread clean", {63'd0, unimpl_bits}, 64'd0);
    access(1'b1, A_DC, c_start(2));
    access(1'b0, AW'(32'h400) << 3, '0);
    chk("R10 bad read flagged", {63'd0, unimpl_access}, 64'd1);
    chk("R10 bad read zero", rd_data, 64'd0);
    access(1'b1, A_STATE, c_stop(0));
    chk("R10 bad write flagged", {63'd0, unimpl_access}, 64'd1);
    pulses_expect("R10 bad write no pulse", '0, '0, '0, '0);
    read_expect("R10 no flag change", A_RAS, 64'h00C0_0000_0000_0000);
    chk("R10 good read clean", {63'd0, unimpl_access}, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_state();
    t_stop_start();
    t_order();
    t_unimpl();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule